// File: doc/BRIEF.md
# Multi-channel DMA trigger selector

This block decides, for each of four DMA channels, which peripheral event starts a transfer. Each channel has a 4-bit selection code. The code picks one trigger source for that channel:

- a software strobe,
- the falling or the rising edge of an asynchronous pin assigned to the channel,
- one of ten peripheral event lines: port events, timer underflow and compare events, serial buffer events, or conversion done.

When the selected source fires, the block raises a request toward the DMA engine and holds it until that engine acknowledges it.

The event lines are taken straight from the peripherals. They do not pass through the interrupt controller's flag, enable or priority logic. The block has no path that could clear a pending interrupt flag, so one event can cause both a transfer and an interrupt.

Software programs the codes through a byte-wide write port and can read them back. Two channels share each byte: the even channel sits in the low nibble and the odd channel in the high nibble.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset every selection code reads 0 and every `dma_req` bit is 0.
- R2: A write at `reg_addr`=A stores `reg_wdata[3:0]` as the code of channel 2A and `reg_wdata[7:4]` as the code of channel 2A+1. `reg_rdata` returns the same layout for the address on `reg_addr`, combinationally.
- R3: With code 0, a one-cycle strobe on `sw_trig[c]` sets `dma_req[c]` at the next rising edge. With any other code, the strobe has no effect.
- R4: Codes 1 and 2 select the falling and the rising edge of `pin_in[c]`. Each pin passes through two synchronizing flops. A level first sampled at clock edge k raises the request at edge k+2.
- R5: For a code n in the range 3 to 12, the channel uses event line `evt_in[c*10 + n-3]`. A high event line sets the request at the next edge. Event lines that are not selected have no effect.
- R6: On channel 0 only, code 11 also accepts `txe_evt`. On every other channel, `txe_evt` has no effect.
- R7: Codes 13, 14 and 15 never set a request.
- R8: `dma_req[c]` stays high until a cycle with `dma_ack[c]` high. Events that arrive while the request is held merge into it. If a selected event arrives in the same cycle as an acknowledge, the request stays high.
- R9: While `ch_en[c]` is low, channel c raises no request. Lowering `ch_en[c]` clears a request that is already held, at the next edge.
- R10: Each channel acts on its own code, pin, events and handshake, with no effect on the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the selection register |
| reg_addr | input | 1 | Byte address of a channel pair |
| reg_wdata | input | 8 | Two selection codes to write |
| reg_rdata | output | 8 | Two selection codes at `reg_addr` |
| ch_en | input | 4 | Per-channel enable from the DMA control |
| sw_trig | input | 4 | Per-channel software trigger strobe |
| pin_in | input | 4 | Asynchronous per-channel trigger pins |
| evt_in | input | 40 | Ten raw event lines per channel |
| txe_evt | input | 1 | Transmit-empty event, used by channel 0 only |
| dma_ack | input | 4 | Acknowledge from the DMA engine |
| dma_req | output | 4 | Request to the DMA engine |

## Verification
The assertions check these properties on every cycle:
- a request is held until it is acknowledged,
- a disabled channel stays silent,
- a reserved code raises nothing new,
- a detected pin edge always matches the level sampled two edges earlier.

The bench runs a behavioural reference model and compares against it on every clock. This comparison shows what the properties cannot: the mapping from each code to its source line, the register nibble layout, the transmit-empty alias on channel 0 alone, software strobes ignored under other codes, and the isolation between channels.

// File: rtl/dts_pkg.sv
package dts_pkg;
    localparam int NUM_CH   = 4;
    localparam int CODE_W   = 4;
    localparam int NUM_EVT  = 10;
    localparam int EVT_BASE = 3;

    typedef enum logic [CODE_W-1:0] {
        SEL_SOFT     = 4'd0,
        SEL_PIN_FALL = 4'd1,
        SEL_PIN_RISE = 4'd2
    } sel_fixed_e;

    typedef struct packed {
        logic stage1;
        logic stage2;
        logic stage3;
    } sync_t;
endpackage

// File: rtl/dts_edge.sv
module dts_edge
    import dts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = pin;
        st_d.stage2 = st_q.stage1;
        st_d.stage3 = st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.stage2 & ~st_q.stage3;
    assign fall = ~st_q.stage2 & st_q.stage3;

    // R4: a detected edge reflects the pin level sampled two edges back
    p_rise_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(pin, 2));
    p_fall_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !$past(pin, 2));
endmodule

// File: rtl/dts_chan.sv
module dts_chan
    import dts_pkg::*;
#(
    parameter int       NEVT    = NUM_EVT,
    parameter int       CW      = CODE_W,
    parameter bit       HAS_TXE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   code,
    input  logic            en,
    input  logic            sw,
    input  logic            rise,
    input  logic            fall,
    input  logic [NEVT-1:0] evt,
    input  logic            txe,
    input  logic            ack,
    output logic            req
);
    localparam int FIRST_EVT = EVT_BASE;
    localparam int LAST_EVT  = EVT_BASE + NEVT - 1;
    localparam int TXE_CODE  = LAST_EVT - 1;

    typedef struct packed {
        logic req;
    } chan_t;

    chan_t st_d, st_q;
    logic  hit;
    logic  txe_use;

    assign txe_use = txe & HAS_TXE;

    always_comb begin
        hit = 1'b0;
        if (code == SEL_SOFT)          hit = sw;
        else if (code == SEL_PIN_FALL) hit = fall;
        else if (code == SEL_PIN_RISE) hit = rise;
        else begin
            for (int i = 0; i < NEVT; i++) begin
                if (int'(code) == FIRST_EVT + i) hit = evt[i];
            end
            if (int'(code) == TXE_CODE) hit = hit | txe_use;
        end

        st_d = st_q;
        if (!en) st_d.req = 1'b0;
        else     st_d.req = (st_q.req & ~ack) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;

    // R8: an unacknowledged request on an enabled channel persists
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && en) |=> req);
    // R9: a disabled channel holds no request in the following cycle
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req);
    // R7: reserved codes never start a request
    p_reserved_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code) > LAST_EVT && !(req && !ack)) |=> !req);
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
    import dts_pkg::*;
#(
    parameter int NCH  = NUM_CH,
    parameter int CW   = CODE_W,
    parameter int NEVT = NUM_EVT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_addr,
    input  logic [2*CW-1:0]      reg_wdata,
    output logic [2*CW-1:0]      reg_rdata,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       sw_trig,
    input  logic [NCH-1:0]       pin_in,
    input  logic [NCH*NEVT-1:0]  evt_in,
    input  logic                 txe_evt,
    input  logic [NCH-1:0]       dma_ack,
    output logic [NCH-1:0]       dma_req
);
    localparam int NPAIR = NCH / 2;

    logic [NCH-1:0][CW-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (reg_wr_en) begin
            sel_d[{reg_addr, 1'b0}] = reg_wdata[CW-1:0];
            sel_d[{reg_addr, 1'b1}] = reg_wdata[2*CW-1:CW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign reg_rdata = {sel_q[{reg_addr, 1'b1}], sel_q[{reg_addr, 1'b0}]};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic rise, fall;

        dts_edge i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_in[c]),
            .rise (rise),
            .fall (fall)
        );

        dts_chan #(
            .NEVT   (NEVT),
            .CW     (CW),
            .HAS_TXE(c == 0)
        ) i_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .code (sel_q[c]),
            .en   (ch_en[c]),
            .sw   (sw_trig[c]),
            .rise (rise),
            .fall (fall),
            .evt  (evt_in[c*NEVT +: NEVT]),
            .txe  (txe_evt),
            .ack  (dma_ack[c]),
            .req  (dma_req[c])
        );
    end

    // R2: a write lands in both nibbles of the addressed pair
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (sel_q[{$past(reg_addr), 1'b0}] == $past(reg_wdata[CW-1:0])) &&
                      (sel_q[{$past(reg_addr), 1'b1}] == $past(reg_wdata[2*CW-1:CW])));

    initial begin
        assert (NPAIR * 2 == NCH);
    end
endmodule

// File: tb/test_dma_trig_sel.sv
module test_dma_trig_sel;
    localparam int NCH  = 4;
    localparam int NEVT = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic              reg_addr = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [NCH-1:0]    ch_en = '0;
    logic [NCH-1:0]    sw_trig = '0;
    logic [NCH-1:0]    pin_in = '0;
    logic [NCH*NEVT-1:0] evt_in = '0;
    logic              txe_evt = 1'b0;
    logic [NCH-1:0]    dma_ack = '1;
    logic [NCH-1:0]    dma_req;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string phase  = "R1";

    always #5 clk = ~clk;

    dma_trig_sel i_dma_trig_sel (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_en(ch_en),
        .sw_trig(sw_trig), .pin_in(pin_in), .evt_in(evt_in), .txe_evt(txe_evt),
        .dma_ack(dma_ack), .dma_req(dma_req)
    );

    // behavioural reference model
    int unsigned m_code [NCH];
    bit [2:0]    m_hist [NCH];
    bit [NCH-1:0] m_req;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_code[c] = 0;
                m_hist[c] = '0;
            end
            m_req = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit fire;
                fire = 1'b0;
                if (m_code[c] == 0) fire = sw_trig[c];
                else if (m_code[c] == 1) fire = !m_hist[c][1] && m_hist[c][2];
                else if (m_code[c] == 2) fire = m_hist[c][1] && !m_hist[c][2];
                else if (m_code[c] <= 12) begin
                    fire = evt_in[c*NEVT + int'(m_code[c]) - 3];
                    if (c == 0 && m_code[c] == 11 && txe_evt) fire = 1'b1;
                end
                if (!ch_en[c]) m_req[c] = 1'b0;
                else m_req[c] = (m_req[c] && !dma_ack[c]) || fire;
                m_hist[c] = {m_hist[c][1:0], pin_in[c]};
            end
            if (reg_wr_en) begin
                m_code[2*reg_addr]   = reg_wdata[3:0];
                m_code[2*reg_addr+1] = reg_wdata[7:4];
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        return {m_code[2*reg_addr+1][3:0], m_code[2*reg_addr][3:0]};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dma_req !== m_req || reg_rdata !== exp_rd()) begin
                fails++;
                $display("FAIL %s: req=%b rdata=%h expected req=%b rdata=%h",
                         phase, dma_req, reg_rdata, m_req, exp_rd());
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        step();
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic a, input logic [7:0] e, input string tag);
        step();
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata, e);
        end
    endtask

    task automatic req_check(input logic [NCH-1:0] e, input string tag);
        checks++;
        if (dma_req !== e) begin
            fails++;
            $display("FAIL %s: req=%b expected %b", tag, dma_req, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        req_check('0, "R1");
        rd_check(1'b0, 8'h00, "R1");
        rd_check(1'b1, 8'h00, "R1");
        ch_en = '1;

        phase = "R2";
        wr(1'b0, 8'h5A);
        wr(1'b1, 8'hC3);
        rd_check(1'b0, 8'h5A, "R2");
        rd_check(1'b1, 8'hC3, "R2");

        phase = "R3";
        wr(1'b0, 8'h50);  // ch0 software, ch1 code 5
        wr(1'b1, 8'h00);  // ch2 and ch3 software
        step(); sw_trig = 4'b1111;
        step(); sw_trig = '0;
        req_check(4'b1101, "R3");
        step(3);

        phase = "R4";
        wr(1'b1, 8'h12);  // ch2 rising edge, ch3 falling edge
        step(); pin_in = 4'b1100;
        step(6);
        step(); pin_in = 4'b0000;
        step(6);
        step(); pin_in = 4'b1111;
        step(2);
        req_check(4'b0000, "R4");
        step();
        req_check(4'b0100, "R4");
        step(4); pin_in = '0; step(5);

        phase = "R5";
        for (int n = 3; n <= 12; n++) begin
            wr(1'b0, {4'(n), 4'd0});
            step(); evt_in = '1; evt_in[NEVT + n - 3] = 1'b0;
            step(); evt_in = '0; evt_in[NEVT + n - 3] = 1'b1;
            step(); evt_in = '0;
            step(2);
        end

        phase = "R6";
        wr(1'b0, 8'hBB);
        wr(1'b1, 8'hBB);
        step(); txe_evt = 1'b1;
        step(); txe_evt = 1'b0;
        req_check(4'b0001, "R6");
        step(3);

        phase = "R7";
        for (int n = 13; n <= 15; n++) begin
            wr(1'b0, {4'(n), 4'(n)});
            wr(1'b1, {4'(n), 4'(n)});
            step(); evt_in = '1; txe_evt = 1'b1; pin_in = '1;
            step(4); evt_in = '0; txe_evt = 1'b0; pin_in = '0;
            step(4);
        end

        phase = "R8";
        wr(1'b0, 8'h30);
        dma_ack = '0;
        step(); sw_trig = 4'b0001;
        step(); sw_trig = '0;
        step(5);
        req_check(4'b0001, "R8");
        evt_in[NEVT] = 1'b1; sw_trig = 4'b0001;
        step(); evt_in = '0; sw_trig = '0;
        dma_ack = 4'b0011; sw_trig = 4'b0001;
        step(); sw_trig = '0;
        req_check(4'b0001, "R8");
        step(); dma_ack = '1;
        step(2);

        phase = "R9";
        dma_ack = '0;
        step(); sw_trig = 4'b0001;
        step(); sw_trig = '0;
        ch_en = 4'b1110;
        step();
        req_check(4'b0000, "R9");
        sw_trig = 4'b0001;
        step(); sw_trig = '0;
        step();
        req_check(4'b0000, "R9");
        ch_en = '1; dma_ack = '1;

        phase = "R10";
        wr(1'b0, 8'h70);
        wr(1'b1, 8'h98);
        step(); evt_in = '0;
        evt_in[2*NEVT + 8 - 3] = 1'b1;
        evt_in[3*NEVT + 9 - 3] = 1'b1;
        step(); evt_in = '0;
        req_check(4'b1100, "R10");
        step(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule